// File: doc/BRIEF.md
# Chained PWM Pixel Readout Decoder

This block is a synchronous controller for an image array whose pixels are read one after another. The array has no clock of its own. The block holds the array's start line low, which keeps every pixel in reset. On a frame request it raises the start line, and that start edge then ripples along a chain that is wired into the array. The array answers on one serial line. Each transition on that line, rising or falling, ends the interval of the current pixel and starts the interval of the next one. Each interval is inversely related to the light on its pixel, so a short interval means a bright pixel.

The controller passes the serial line through a synchroniser and times the gap between transitions with a saturating cycle counter. It writes each gap to a pixel port, together with the row and column that the chain's position maps to. The default chain is a serpentine path: even rows run left to right and odd rows run right to left. A parameter selects a plain raster path instead. The total frame time depends on the scene, because it is the sum of all the pixel intervals. Once the last pixel has been captured, the block drops the start line and flags the end of the frame.

Top module: `pwm_chain_reader`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `sensorIn`, `pixWe`, `frameDone` and `timeoutFlag` are all 0.
- R2: If `frameReq` is high at a clock edge while no frame is running, `sensorIn` is 1 after that edge. A `frameReq` during a running frame has no effect: `sensorIn` stays 1 and the capture order is unchanged.
- R3: While a frame runs, every rising edge and every falling edge of `sensorOut` produces exactly one `pixWe` pulse.
- R4: A write's `pixVal` is the number of clock cycles between the two `sensorOut` transitions that bound it. For the first pixel, the count runs from the edge that raised `sensorIn`, and it includes the two synchroniser cycles, so an input transition whose new level is first sampled N edges after that edge gives N+2.
- R5: With the default path, the k-th write of a frame (k counted from 0) goes to row k/COLS. Its column is k%COLS on even rows and COLS-1-k%COLS on odd rows.
- R6: An interval of 65535 cycles or more is written as 65535 (all ones). The interval counter never wraps.
- R7: `timeoutFlag` goes high once an interval reaches 65535 cycles. It stays high until the next frame request is accepted, which clears it.
- R8: The ROWS*COLS-th write of a frame comes with a one-cycle `frameDone` pulse in the same cycle, and `sensorIn` is 0 from that cycle on.
- R9: `sensorOut` transitions while no frame is running produce no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameReq | input | 1 | Request to start one frame |
| sensorOut | input | 1 | Asynchronous serial line from the array |
| sensorIn | output | 1 | Start line to the array; low holds the pixels in reset |
| pixWe | output | 1 | Pixel write strobe |
| pixRow | output | 3 | Row of the pixel being written |
| pixCol | output | 4 | Column of the pixel being written |
| pixVal | output | 16 | Measured interval in clock cycles |
| frameDone | output | 1 | One-cycle pulse with the last write of a frame |
| timeoutFlag | output | 1 | An interval of the current frame reached the counter limit |

## Verification
A wrong chain index appears immediately as row and column values that break the serpentine order. It also moves `frameDone` away from the 72nd write, or leaves `sensorIn` high after that write. A counter that is not cleared on capture, or not held at its limit, shows up at the very next write as a `pixVal` that differs from the gap the stimulus produced. A wrong state after the end of a frame shows up as writes caused by stray idle transitions, or as a request that fails to raise `sensorIn` one cycle later.

// File: rtl/pwm_chain_pkg.sv
package pwm_chain_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic startFrame; // clear counter and timeout at frame start
    logic counting;   // frame running, counter advances
    logic capture;    // a transition was seen, write the pixel
  } chain_strobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } chain_state_t;

  // Row visited at chain position idx
  function automatic int unsigned pathRow(int unsigned idx, int unsigned cols);
    return idx / cols;
  endfunction

  // Column visited at chain position idx; mode 0 = serpentine, 1 = raster
  function automatic int unsigned pathCol(int unsigned idx, int unsigned cols,
                                          int unsigned mode);
    int unsigned r;
    int unsigned c;
    r = idx / cols;
    c = idx % cols;
    if (mode == 0 && (r % 2) == 1) c = cols - 1 - c;
    return c;
  endfunction

endpackage

// File: rtl/pwm_chain_datapath.sv
module pwm_chain_datapath
  import pwm_chain_pkg::*;
#(
  parameter int ROWS        = 6,
  parameter int COLS        = 12,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PATH_MODE   = 0,
  localparam int PIX   = ROWS * COLS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int IDX_W = (PIX > 1) ? $clog2(PIX) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sensorOut,
  input  chain_strobe_t    strobe,
  input  logic [IDX_W-1:0] seqIdx,
  output logic             edgeSeen,
  output logic             pixWe,
  output logic [ROW_W-1:0] pixRow,
  output logic [COL_W-1:0] pixCol,
  output logic [CNT_W-1:0] pixVal,
  output logic             timeoutFlag
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // Synchroniser for the asynchronous serial line
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   prevLevel;
  logic                   syncLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], sensorOut};
  end

  assign syncLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= 1'b0;
    else       prevLevel <= syncLevel;
  end

  assign edgeSeen = syncLevel ^ prevLevel;

  // Chain position to row/column table, computed at elaboration
  logic [ROW_W-1:0] lutRow [PIX];
  logic [COL_W-1:0] lutCol [PIX];

  generate
    for (genvar k = 0; k < PIX; k++) begin : g_path
      assign lutRow[k] = ROW_W'(pathRow(k, COLS));
      assign lutCol[k] = COL_W'(pathCol(k, COLS, PATH_MODE));
    end
  endgenerate

  // Saturating interval counter
  logic [CNT_W-1:0] intervalCnt;
  logic [CNT_W-1:0] captureVal;

  assign captureVal = (intervalCnt == CNT_MAX) ? CNT_MAX : intervalCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
      timeoutFlag <= 1'b0;
    end else if (strobe.startFrame) begin
      intervalCnt <= '0;
      timeoutFlag <= 1'b0;
    end else if (strobe.counting) begin
      if (strobe.capture)              intervalCnt <= '0;
      else if (intervalCnt != CNT_MAX) intervalCnt <= intervalCnt + 1'b1;
      if (intervalCnt == CNT_MAX)      timeoutFlag <= 1'b1;
    end
  end

  // Pixel write port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixWe  <= 1'b0;
      pixRow <= '0;
      pixCol <= '0;
      pixVal <= '0;
    end else begin
      pixWe <= strobe.capture;
      if (strobe.capture) begin
        pixRow <= lutRow[seqIdx];
        pixCol <= lutCol[seqIdx];
        pixVal <= captureVal;
      end
    end
  end

endmodule

// File: rtl/pwm_chain_ctrl.sv
module pwm_chain_ctrl
  import pwm_chain_pkg::*;
#(
  parameter int ROWS  = 6,
  parameter int COLS  = 12,
  localparam int PIX   = ROWS * COLS,
  localparam int IDX_W = (PIX > 1) ? $clog2(PIX) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameReq,
  input  logic             edgeSeen,
  output chain_strobe_t    strobe,
  output logic [IDX_W-1:0] seqIdx,
  output logic             sensorIn,
  output logic             frameDone
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX - 1);

  chain_state_t state;

  always_comb begin
    strobe.startFrame = (state == ST_IDLE) && frameReq;
    strobe.counting   = (state == ST_RUN);
    strobe.capture    = (state == ST_RUN) && edgeSeen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      sensorIn  <= 1'b0;
      seqIdx    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (frameReq) begin
            state    <= ST_RUN;
            sensorIn <= 1'b1;
            seqIdx   <= '0;
          end
        end
        ST_RUN: begin
          if (edgeSeen) begin
            if (seqIdx == LAST_IDX) begin
              state     <= ST_IDLE;
              sensorIn  <= 1'b0;
              frameDone <= 1'b1;
            end else begin
              seqIdx <= seqIdx + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwm_chain_reader.sv
module pwm_chain_reader
  import pwm_chain_pkg::*;
#(
  parameter int ROWS        = 6,
  parameter int COLS        = 12,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PATH_MODE   = 0,
  localparam int PIX   = ROWS * COLS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int IDX_W = (PIX > 1) ? $clog2(PIX) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameReq,
  input  logic             sensorOut,
  output logic             sensorIn,
  output logic             pixWe,
  output logic [ROW_W-1:0] pixRow,
  output logic [COL_W-1:0] pixCol,
  output logic [CNT_W-1:0] pixVal,
  output logic             frameDone,
  output logic             timeoutFlag
);

  chain_strobe_t    strobe;
  logic [IDX_W-1:0] seqIdx;
  logic             edgeSeen;

  pwm_chain_ctrl #(
    .ROWS(ROWS),
    .COLS(COLS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameReq (frameReq),
    .edgeSeen (edgeSeen),
    .strobe   (strobe),
    .seqIdx   (seqIdx),
    .sensorIn (sensorIn),
    .frameDone(frameDone)
  );

  pwm_chain_datapath #(
    .ROWS       (ROWS),
    .COLS       (COLS),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .PATH_MODE  (PATH_MODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sensorOut  (sensorOut),
    .strobe     (strobe),
    .seqIdx     (seqIdx),
    .edgeSeen   (edgeSeen),
    .pixWe      (pixWe),
    .pixRow     (pixRow),
    .pixCol     (pixCol),
    .pixVal     (pixVal),
    .timeoutFlag(timeoutFlag)
  );

endmodule

// File: rtl/pwm_chain_reader_chk.sv
module pwm_chain_reader_chk #(
  parameter int ROWS  = 6,
  parameter int COLS  = 12,
  parameter int CNT_W = 16,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameReq,
  input logic             sensorIn,
  input logic             pixWe,
  input logic [ROW_W-1:0] pixRow,
  input logic [COL_W-1:0] pixCol,
  input logic [CNT_W-1:0] pixVal,
  input logic             frameDone,
  input logic             timeoutFlag
);

  // R2: the start line only rises after an accepted request
  a_r2_start_on_request: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sensorIn) |-> $past(frameReq));

  // R3, R9: writes only come from a running frame
  a_r9_write_only_running: assert property (@(posedge clk) disable iff (!rstN)
    pixWe |-> $past(sensorIn));

  // R4: every interval holds at least one cycle
  a_r4_nonzero_value: assert property (@(posedge clk) disable iff (!rstN)
    pixWe |-> pixVal != '0);

  // R5: the address stays inside the array
  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rstN)
    pixWe |-> (pixRow < ROW_W'(ROWS)) && (pixCol < COL_W'(COLS)));

  // R8: the end flag comes with the last write and the start line low
  a_r8_done_with_write: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> pixWe && !sensorIn);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);

  // R7: the timeout flag only clears when a new frame starts
  a_r7_timeout_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeoutFlag) |-> $rose(sensorIn));

endmodule

bind pwm_chain_reader pwm_chain_reader_chk #(
  .ROWS (ROWS),
  .COLS (COLS),
  .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameReq   (frameReq),
  .sensorIn   (sensorIn),
  .pixWe      (pixWe),
  .pixRow     (pixRow),
  .pixCol     (pixCol),
  .pixVal     (pixVal),
  .frameDone  (frameDone),
  .timeoutFlag(timeoutFlag)
);

// File: tb/pwm_chain_reader_tb.sv
`timescale 1ns/1ps
module pwm_chain_reader_tb;

  localparam int ROWS  = 6;
  localparam int COLS  = 12;
  localparam int PIX   = ROWS * COLS;
  localparam int CMAX  = 65535;
  localparam int SYNCL = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameReq = 1'b0;
  logic        sensorOut = 1'b0;
  logic        sensorIn;
  logic        pixWe;
  logic [2:0]  pixRow;
  logic [3:0]  pixCol;
  logic [15:0] pixVal;
  logic        frameDone;
  logic        timeoutFlag;

  int total = 0;
  int bad = 0;
  int expV [PIX];
  int wrIdx = 0;
  int doneCnt = 0;
  bit expectWrites = 0;
  bit prevIn = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwm_chain_reader u_dut (
    .clk(clk), .rstN(rstN), .frameReq(frameReq), .sensorOut(sensorOut),
    .sensorIn(sensorIn), .pixWe(pixWe), .pixRow(pixRow), .pixCol(pixCol),
    .pixVal(pixVal), .frameDone(frameDone), .timeoutFlag(timeoutFlag)
  );

  function automatic int expRow(int k);
    return k / COLS;
  endfunction

  function automatic int expCol(int k);
    int c;
    c = k % COLS;
    if ((k / COLS) % 2 == 1) c = COLS - 1 - c;
    return c;
  endfunction

  function automatic int expValue(int d, bit first);
    int v;
    v = first ? d + SYNCL : d;
    return (v > CMAX) ? CMAX : v;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: compare every write against the bench's expectation
  always @(negedge clk) begin
    if (rstN) begin
      if (sensorIn && !prevIn) begin
        wrIdx = 0;
        doneCnt = 0;
      end
      prevIn = sensorIn;
      if (pixWe) begin
        if (!expectWrites || wrIdx >= PIX) begin
          check("R9 unexpected write", 1, 0);
        end else begin
          check("R4 value", int'(pixVal), expV[wrIdx]);
          check("R5 row", int'(pixRow), expRow(wrIdx));
          check("R5 col", int'(pixCol), expCol(wrIdx));
          wrIdx++;
        end
      end
      if (frameDone) begin
        doneCnt++;
        check("R8 done at last write", wrIdx, PIX);
        check("R8 start line low", int'(sensorIn), 0);
      end
    end
  end

  // One frame; dly[k] = cycles before transition k; satIdx = long gap index or -1
  task automatic runFrame(int dly [PIX], int midReqIdx, int satIdx);
    for (int k = 0; k < PIX; k++) expV[k] = expValue(dly[k], k == 0);
    expectWrites = 1;
    @(negedge clk);
    frameReq = 1'b1;
    @(negedge clk);
    frameReq = 1'b0;
    check("R2 start line raised", int'(sensorIn), 1);
    check("R7 timeout cleared at start", int'(timeoutFlag), 0);
    for (int k = 0; k < PIX; k++) begin
      repeat ((k == 0) ? dly[k] - 1 : dly[k]) @(negedge clk);
      if (k == satIdx) check("R7 timeout set", int'(timeoutFlag), 1);
      sensorOut = ~sensorOut;
      if (k == midReqIdx) frameReq = 1'b1;
      if (k == midReqIdx + 1) begin
        frameReq = 1'b0;
        check("R2 request ignored while running", int'(sensorIn), 1);
      end
    end
    repeat (6) @(negedge clk);
    check("R3 write count", wrIdx, PIX);
    check("R8 single done pulse", doneCnt, 1);
    check("R8 start line low after frame", int'(sensorIn), 0);
    if (satIdx < 0) check("R7 no timeout", int'(timeoutFlag), 0);
    else            check("R6 timeout kept", int'(timeoutFlag), 1);
    expectWrites = 0;
  endtask

  task automatic idleToggles();
    for (int k = 0; k < 4; k++) begin
      repeat (5) @(negedge clk);
      sensorOut = ~sensorOut;
    end
    repeat (6) @(negedge clk);
    check("R9 idle level kept", int'(sensorIn), 0);
  endtask

  initial begin
    int dly [PIX];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 start line in reset", int'(sensorIn), 0);
    check("R1 write in reset", int'(pixWe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 start line after reset", int'(sensorIn), 0);
    check("R1 done after reset", int'(frameDone), 0);
    check("R1 timeout after reset", int'(timeoutFlag), 0);

    // Directed: shortest gaps everywhere
    for (int k = 0; k < PIX; k++) dly[k] = 1;
    runFrame(dly, -10, -1);
    idleToggles();

    // Random gaps with a request in the middle of the frame
    for (int k = 0; k < PIX; k++) dly[k] = $urandom_range(24, 1);
    runFrame(dly, 10, -1);
    idleToggles();

    // Random gaps with one dark pixel past the counter limit (R6)
    for (int k = 0; k < PIX; k++) dly[k] = $urandom_range(20, 1);
    dly[5] = 70000;
    runFrame(dly, -10, 5);

    // Random frame after the timeout: flag cleared, values normal
    for (int k = 0; k < PIX; k++) dly[k] = $urandom_range(30, 2);
    runFrame(dly, -10, -1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule